// File: doc/BRIEF.md
# Bit-Serial Eight-Operand Adder Tree

This block adds eight wide unsigned words that arrive one bit per clock, least significant bit first. Each operand lane carries one serial bit per cycle. A single strobe marks the cycle that holds the lowest bit of a new set of words. Inside, seven one-bit adders form a three-level tree: four adders, then two, then one. Each adder keeps its carry in a flip-flop, so the carry from one bit position becomes the carry-in of the next.

The result leaves as a serial bit stream, lowest bit first, together with a flag that marks the result's lowest bit. Every tree level is one register stage, so each result bit appears three clocks after the matching input bit. Any growth beyond the operand width is dropped, so each result is the sum modulo 2^WORD_BITS. A new set of words may start on the cycle right after the last bit of the previous set, which keeps every adder busy on every clock. Idle cycles between sets are also allowed.

Top module: `serial_sum_tree`

## Requirements
- R1: For every operand set, the WORD_BITS result bits that follow a result-start flag equal the sum of the eight operands modulo 2^WORD_BITS. Carries propagate from each bit position into the next.
- R2: Every adder clears its carry on the cycle that carries the lowest bit of a new word. An all-ones set followed at once by an all-zeros set therefore gives an all-zeros result for the second set.
- R3: Result bits leave lowest bit first. Bit i of a result appears on `sum_bit` exactly three clocks after bit i of the operands was presented on `op_bits`.
- R4: `sum_first` is high exactly three clocks after each `frame_start`, on the cycle that carries the result's lowest bit, and it is low on every other cycle.
- R5: Operand sets may follow each other with `frame_start` exactly every WORD_BITS cycles and no idle cycle, and each result stays correct. Two strobes less than WORD_BITS cycles apart are not permitted.
- R6: A synchronous, active-high `rst` clears all carry and stage registers. During reset, and after reset while the operand inputs are held at zero with no strobe, both outputs stay 0. This holds even if a partial all-ones word was in flight.
- R7: Any number of idle cycles may pass between the last bit of one set and the next `frame_start`, and the next result is still correct.
- R8: Eight all-ones operands produce the result 2^WORD_BITS - 8, which exercises the longest chains of carries at every level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_bits | input | NUM_OPS (8) | One serial bit of each operand for the current bit position |
| frame_start | input | 1 | High on the cycle carrying the lowest bit of a new operand set |
| sum_bit | output | 1 | Serial result bit, lowest bit first |
| sum_first | output | 1 | High on the cycle carrying the lowest bit of a result |

## Verification
Every result bit and every result-start flag is due exactly three clocks after the input cycle that produced it, one clock per tree level. The bench keeps a queue of expected entries, one pushed for each driven input cycle. It compares the entry that is three cycles old against the outputs at each falling edge. Cycles that fall between operand sets are marked as don't-care for the data bit, but the flag is still checked on them. After a mid-stream reset, the queue is refilled with zero expectations, so the cleared state is checked from the first cycle after reset.

// File: rtl/sertree_pkg.sv
package sertree_pkg;

    // One-bit full adder result: sum and carry-out.
    typedef struct packed {
        logic sum;
        logic carry;
    } fa_out_t;

    function automatic fa_out_t full_add(input logic a, input logic b, input logic cin);
        fa_out_t r;
        r.sum   = a ^ b ^ cin;
        r.carry = (a & b) | (cin & (a ^ b));
        return r;
    endfunction

endpackage

// File: rtl/sertree_cell.sv
module sertree_cell
    import sertree_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic first,
    input  logic a,
    input  logic b,
    output logic sum_q
);

    logic    carry_q;
    logic    cin;
    fa_out_t fa;

    // The carry is forced to zero on the lowest bit of a new word.
    assign cin = first ? 1'b0 : carry_q;
    assign fa  = full_add(a, b, cin);

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q   <= 1'b0;
            carry_q <= 1'b0;
        end else begin
            sum_q   <= fa.sum;
            carry_q <= fa.carry;
        end
    end

    // R2: no stale carry leaks into the lowest bit of a word
    assert_lsb_no_carry_R2: assert property (@(posedge clk) disable iff (rst)
        (first && !a && !b) |=> !sum_q);

    // R1: a generated carry reaches the next bit position
    assert_carry_forward_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(a && b) && !first && !a && !b) |=> sum_q);

endmodule

// File: rtl/sertree_level.sv
module sertree_level #(
    parameter  int N_OUT = 1,
    localparam int N_IN  = 2 * N_OUT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_first,
    input  logic [N_IN-1:0]  in_bits,
    output logic             out_first,
    output logic [N_OUT-1:0] out_bits
);

    for (genvar j = 0; j < N_OUT; j++) begin : g_cell
        sertree_cell u_cell (
            .clk   (clk),
            .rst   (rst),
            .first (in_first),
            .a     (in_bits[2*j]),
            .b     (in_bits[2*j+1]),
            .sum_q (out_bits[j])
        );
    end

    // The word-start marker moves down the tree in step with the data.
    always_ff @(posedge clk) begin
        if (rst) out_first <= 1'b0;
        else     out_first <= in_first;
    end

    // R4: the marker advances by exactly one level per clock
    assert_marker_step_R4: assert property (@(posedge clk) disable iff (rst)
        in_first |=> out_first);

endmodule

// File: rtl/serial_sum_tree.sv
module serial_sum_tree #(
    parameter  int WORD_BITS = 1024,
    parameter  int LOG_OPS   = 3,
    localparam int NUM_OPS   = 1 << LOG_OPS
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_OPS-1:0] op_bits,
    input  logic               frame_start,
    output logic               sum_bit,
    output logic               sum_first
);

    localparam int CW = $clog2(WORD_BITS + 1);

    // Heap-indexed tree nodes: node 1 is the root, and node i has children 2i and 2i+1.
    logic [2*NUM_OPS-1:1] node_bit;
    logic [LOG_OPS:0]     lvl_first;

    assign node_bit[2*NUM_OPS-1:NUM_OPS] = op_bits;
    assign lvl_first[LOG_OPS]            = frame_start;

    for (genvar d = 0; d < LOG_OPS; d++) begin : g_level
        sertree_level #(.N_OUT(1 << d)) u_level (
            .clk       (clk),
            .rst       (rst),
            .in_first  (lvl_first[d+1]),
            .in_bits   (node_bit[(4<<d)-1:(2<<d)]),
            .out_first (lvl_first[d]),
            .out_bits  (node_bit[(2<<d)-1:(1<<d)])
        );
    end

    assign sum_bit   = node_bit[1];
    assign sum_first = lvl_first[0];

    // Cycles since the last strobe, saturating; used to check strobe spacing.
    logic [CW-1:0] since_frame;
    logic          frame_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            since_frame <= '0;
            frame_seen  <= 1'b0;
        end else if (frame_start) begin
            since_frame <= CW'(1);
            frame_seen  <= 1'b1;
        end else if (frame_seen && since_frame < CW'(WORD_BITS)) begin
            since_frame <= since_frame + CW'(1);
        end
    end

    // R5: strobes are never closer than one word apart
    assert_frame_spacing_R5: assert property (@(posedge clk) disable iff (rst)
        (frame_start && frame_seen) |-> since_frame >= CW'(WORD_BITS));

    // R4: the result-start flag follows the strobe after one clock per level
    assert_first_latency_R4: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> ##LOG_OPS sum_first);

    // R4: the result-start flag never appears without a matching strobe
    assert_first_source_R4: assert property (@(posedge clk) disable iff (rst)
        sum_first |-> $past(frame_start, LOG_OPS));

    // R6: the outputs are cleared on the clock after reset is sampled
    assert_reset_clear_R6: assert property (@(posedge clk)
        rst |=> (!sum_bit && !sum_first));

endmodule

// File: tb/serial_sum_tree_tb.sv
`timescale 1ns/1ps
module serial_sum_tree_tb;

    localparam int W   = 64;
    localparam int OPS = 8;
    localparam int LAT = 3;

    typedef struct {
        bit    care;
        bit    b;
        bit    f;
        string tag;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [OPS-1:0] op_bits = '0;
    logic           frame_start = 1'b0;
    logic           sum_bit;
    logic           sum_first;

    exp_t q[$];
    int   n_run  = 0;
    int   n_fail = 0;

    always #2 clk = ~clk;

    serial_sum_tree #(.WORD_BITS(W), .LOG_OPS(3)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .op_bits     (op_bits),
        .frame_start (frame_start),
        .sum_bit     (sum_bit),
        .sum_first   (sum_first)
    );

    // One clock: check the entry due now (three cycles old), then drive the next input.
    task automatic step(input logic [OPS-1:0] bits, input logic fs, input exp_t e);
        @(negedge clk);
        if (q.size() == LAT) begin
            exp_t h;
            h = q.pop_front();
            n_run++;
            if (sum_first !== h.f) begin
                n_fail++;
                $display("FAIL R4 (%s) sum_first=%b expected %b at %0t", h.tag, sum_first, h.f, $time);
            end
            if (h.care) begin
                n_run++;
                if (sum_bit !== h.b) begin
                    n_fail++;
                    $display("FAIL %s/R3 sum_bit=%b expected %b at %0t", h.tag, sum_bit, h.b, $time);
                end
            end
        end
        op_bits     = bits;
        frame_start = fs;
        q.push_back(e);
    endtask

    task automatic send_word(input logic [W-1:0] ops [OPS], input string tag);
        logic [W-1:0] s;
        s = '0;
        for (int k = 0; k < OPS; k++) s = s + ops[k];
        for (int i = 0; i < W; i++) begin
            logic [OPS-1:0] bits;
            exp_t e;
            for (int k = 0; k < OPS; k++) bits[k] = ops[k][i];
            e = '{care: 1'b1, b: s[i], f: (i == 0), tag: tag};
            step(bits, (i == 0), e);
        end
    endtask

    task automatic idle(input int n, input bit chk, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_t e;
            e = '{care: chk, b: 1'b0, f: 1'b0, tag: tag};
            step('0, 1'b0, e);
        end
    endtask

    task automatic rand_ops(output logic [W-1:0] ops [OPS]);
        for (int k = 0; k < OPS; k++)
            for (int c = 0; c < W / 32; c++) ops[k][c*32 +: 32] = $urandom;
    endtask

    task automatic summary;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired at %0t", $time);
        summary();
        $finish;
    end

    initial begin
        logic [W-1:0] ops [OPS];

        // R6: outputs held clear while reset is asserted
        repeat (4) @(negedge clk);
        n_run++;
        if (sum_bit !== 1'b0 || sum_first !== 1'b0) begin
            n_fail++;
            $display("FAIL R6 outputs during reset bit=%b first=%b expected 0 0", sum_bit, sum_first);
        end
        rst = 1'b0;

        // R1: random sets
        rand_ops(ops); send_word(ops, "R1");
        // R5: further sets back to back, no idle cycle
        for (int n = 0; n < 3; n++) begin
            rand_ops(ops); send_word(ops, "R5");
        end

        // R8: all ones, the longest carry chains
        for (int k = 0; k < OPS; k++) ops[k] = '1;
        send_word(ops, "R8");
        // R2: all zeros right after; carries must not leak in
        for (int k = 0; k < OPS; k++) ops[k] = '0;
        send_word(ops, "R2");

        // R7: idle gap between sets, then a new set
        idle(7, 1'b0, "R7");
        rand_ops(ops); send_word(ops, "R7");

        // R1: shifted single-bit operands plus one near-full operand
        for (int k = 0; k < OPS; k++) ops[k] = W'(1) << (k * 7);
        ops[OPS-1] = {W{1'b1}} - W'(3);
        send_word(ops, "R1");
        rand_ops(ops); send_word(ops, "R1");
        idle(LAT, 1'b0, "R1");

        // R6: partial all-ones word, then reset mid-stream
        for (int i = 0; i < 10; i++) begin
            exp_t e;
            e = '{care: 1'b0, b: 1'b0, f: (i == 0), tag: "R6"};
            step('1, (i == 0), e);
        end
        @(negedge clk);
        rst = 1'b1;
        op_bits = '0;
        frame_start = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        q.delete();
        for (int i = 0; i < LAT; i++) q.push_back('{care: 1'b1, b: 1'b0, f: 1'b0, tag: "R6"});
        idle(8, 1'b1, "R6");

        // R6: normal operation resumes after reset
        rand_ops(ops); send_word(ops, "R6");
        idle(LAT, 1'b0, "R6");

        summary();
        $finish;
    end

endmodule